// File: doc/BRIEF.md
# Prescaled Reload Timer with Toggle Output

This block is an interval timer built from two cascaded down-counters. The first stage is a prescaler. It advances on a count source chosen from four clock-enable inputs. The second stage is the timer, which advances once each time the prescaler wraps. Each stage keeps a reload value. When a stage passes zero, it reloads that value and goes on counting. Every timer wrap inverts a pulse output and raises a one-cycle underflow interrupt.

Software reaches the block through a small register port. It can load and read back either counter and pick the count source. It can also start and stop counting, choose the level the pulse output starts at, and route a complementary copy of the pulse to a second pin. When that route is disabled, the second pin carries a plain port value. A second interrupt fires on the output edge that matches the polarity choice. While the timer is stopped, changing the polarity moves the output to the new starting level at once, and that move raises no interrupt.

Top module: `pulse_reload_timer`

## Requirements
- R1: Control bits [1:0] pick the count source: 0 = `src_full`, 1 = `src_div8`, 2 = `src_div32`, 3 = `src_sub`. Only the picked enable advances the prescaler.
- R2: Both counters count down. In the cycle a counter advances from 0, it reloads its reload value instead.
- R3: Take prescaler setting n and timer setting m. After counting starts, the timer wraps on every (n+1)*(m+1)-th count-source tick.
- R4: Control bit 3 is the run flag. While it is 0, both counters hold their values, no underflow interrupt is raised, and the output holds its level.
- R5: `pulse_out` inverts in the cycle after each timer wrap.
- R6: Control bit 2 is the polarity. With 0 the output starts high and `irq_edge` marks rising edges. With 1 it starts low and `irq_edge` marks falling edges. `irq_edge` occurs only together with `irq_underflow`.
- R7: `irq_underflow` is high for exactly one cycle, the cycle after each timer wrap.
- R8: Control bit 4 enables the complementary pin. When it is 1, `pulse_out_n` equals the inverse of `pulse_out`. When it is 0, `pulse_out_n` equals `port_val`.
- R9: Register 0 is the prescaler and register 1 is the timer. A write sets both the reload value and the live count. A read returns the live count.
- R10: After reset, the control register (address 2) reads 0, both counters read 0, `pulse_out` is 1, and both interrupts are 0.
- R11: While stopped, a write that changes the polarity sets `pulse_out` to the new starting level on the next cycle, and `irq_edge` stays 0.
- R12: A write to a counter in the cycle where that counter would wrap takes priority. The counter takes the written value, and the wrap, its interrupt and its toggle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_full | input | 1 | Undivided count-source enable |
| src_div8 | input | 1 | Divide-by-8 count-source enable |
| src_div32 | input | 1 | Divide-by-32 count-source enable |
| src_sub | input | 1 | Slow sub-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 prescaler, 1 timer, 2 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` |
| port_val | input | 1 | General-purpose value for the complementary pin |
| pulse_out | output | 1 | Toggling pulse output |
| pulse_out_n | output | 1 | Inverted pulse or `port_val` |
| irq_underflow | output | 1 | Timer wrap interrupt pulse |
| irq_edge | output | 1 | Output edge interrupt pulse |

## Verification
A software write to the timer can land in the very cycle where the timer would pass zero. The bench provokes this by running with an undivided source and a one-tick prescaler, counting the exact edge at which the timer reaches 0, and issuing the timer write on that edge. The write must win. The read-back must show the written value, and neither an interrupt nor an output toggle may follow in the next cycle.

// File: rtl/prt_pkg.sv
// Package: shared control-register layout and address map for the
// prescaled reload timer. Assumes an 8-bit control register.
package prt_pkg;

    typedef enum logic [1:0] {
        SRC_FULL  = 2'd0,
        SRC_DIV8  = 2'd1,
        SRC_DIV32 = 2'd2,
        SRC_SUB   = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic [2:0] spare;
        logic       comp_en;
        logic       run;
        logic       pol;
        src_sel_e   src;
    } ctrl_t;

    localparam int CTL_W   = $bits(ctrl_t);
    localparam int POL_POS = 2;

    localparam logic [1:0] ADDR_PRE = 2'd0;
    localparam logic [1:0] ADDR_TMR = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/prt_src_mux.sv
// Module: picks one of N_SRC clock-enable inputs as the count tick.
// Assumes the enables are already synchronous to clk.
module prt_src_mux #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] src_ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    // Select the active enable.
    always_comb begin
        tick = src_ticks[sel];
    end

endmodule

// File: rtl/prt_down_counter.sv
// Module: down-counter with a reload register. A load writes both the
// reload value and the live count and overrides counting. uf flags the
// cycle in which an advance from zero wraps to the reload value.
module prt_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         uf
);

    logic [W-1:0] rel_q;

    // Wrap strobe: an advance from zero that no load overrides.
    always_comb begin
        uf = en && !load && (cnt == '0);
    end

    // Load, count down, or reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            rel_q <= '0;
        end else if (load) begin
            cnt   <= load_val;
            rel_q <= load_val;
        end else if (en) begin
            cnt <= (cnt == '0) ? rel_q : cnt - 1'b1;
        end
    end

    assert_reload_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> cnt == rel_q);

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));

    assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

endmodule

// File: rtl/prt_toggle_out.sv
// Module: pulse output and interrupt pulses. The output inverts on each
// timer wrap. A forced level (stopped polarity change) wins and raises
// no edge interrupt. Assumes force and uf never coincide.
module prt_toggle_out (
    input  logic clk,
    input  logic rst_n,
    input  logic uf,
    input  logic pol,
    input  logic force_req,
    input  logic force_lvl,
    output logic out_q,
    output logic irq_uf,
    output logic irq_edge
);

    // Output level: forced start level, toggle on wrap, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (force_req) begin
            out_q <= force_lvl;
        end else if (uf) begin
            out_q <= ~out_q;
        end
    end

    // Interrupt pulses: wrap and the polarity-selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_uf   <= 1'b0;
            irq_edge <= 1'b0;
        end else begin
            irq_uf   <= uf && !force_req;
            irq_edge <= uf && !force_req && (out_q == pol);
        end
    end

    assert_toggle_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !force_req) |=> out_q != $past(out_q));

    assert_edge_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> out_q != $past(pol));

    assert_force_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |=> !irq_edge);

endmodule

// File: rtl/pulse_reload_timer.sv
// Module: top of the prescaled reload timer. Holds the control register,
// cascades prescaler into timer, and drives the pulse pins and interrupts.
// Assumes a single register port where reg_addr serves reads and writes.
module pulse_reload_timer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_full,
    input  logic              src_div8,
    input  logic              src_div32,
    input  logic              src_sub,
    input  logic              wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              port_val,
    output logic              pulse_out,
    output logic              pulse_out_n,
    output logic              irq_underflow,
    output logic              irq_edge
);
    import prt_pkg::*;

    localparam int N_SRC = 4;

    ctrl_t             ctrl_q;
    logic              ctl_wr, pre_wr, tmr_wr;
    logic              src_tick, tick;
    logic              pre_uf, tmr_uf;
    logic [DATA_W-1:0] pre_cnt, tmr_cnt;
    logic              force_req, force_lvl;

    // Decode register writes and the stopped polarity change.
    always_comb begin
        ctl_wr    = wr_en && (reg_addr == ADDR_CTL);
        pre_wr    = wr_en && (reg_addr == ADDR_PRE);
        tmr_wr    = wr_en && (reg_addr == ADDR_TMR);
        force_req = ctl_wr && !ctrl_q.run && (wr_data[POL_POS] != ctrl_q.pol);
        force_lvl = ~wr_data[POL_POS];
        tick      = src_tick && ctrl_q.run;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctl_wr) begin
            ctrl_q <= ctrl_t'(wr_data[CTL_W-1:0]);
        end
    end

    prt_src_mux #(.N_SRC(N_SRC)) u_src (
        .src_ticks ({src_sub, src_div32, src_div8, src_full}),
        .sel       (ctrl_q.src),
        .tick      (src_tick)
    );

    prt_down_counter #(.W(DATA_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tick),
        .load     (pre_wr),
        .load_val (wr_data),
        .cnt      (pre_cnt),
        .uf       (pre_uf)
    );

    prt_down_counter #(.W(DATA_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pre_uf),
        .load     (tmr_wr),
        .load_val (wr_data),
        .cnt      (tmr_cnt),
        .uf       (tmr_uf)
    );

    prt_toggle_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .uf        (tmr_uf),
        .pol       (ctrl_q.pol),
        .force_req (force_req),
        .force_lvl (force_lvl),
        .out_q     (pulse_out),
        .irq_uf    (irq_underflow),
        .irq_edge  (irq_edge)
    );

    // Read mux and complementary pin.
    always_comb begin
        case (reg_addr)
            ADDR_PRE: rd_data = pre_cnt;
            ADDR_TMR: rd_data = tmr_cnt;
            ADDR_CTL: rd_data = DATA_W'(ctrl_q);
            default:  rd_data = '0;
        endcase
        pulse_out_n = ctrl_q.comp_en ? ~pulse_out : port_val;
    end

    assert_stopped_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |=> !irq_underflow);

    assert_edge_needs_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> irq_underflow);

    assert_stopped_holds_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !force_req) |=> $stable(pulse_out));

endmodule

// File: tb/pulse_reload_timer_tb.sv
module pulse_reload_timer_tb;

    typedef struct {
        int cyc;
        bit lvl;
        bit edg;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_full = 1'b0, src_div8 = 1'b0, src_div32 = 1'b0, src_sub = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       port_val = 1'b1;
    logic       pulse_out, pulse_out_n, irq_underflow, irq_edge;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    int   uf_seen = 0;
    int   edge_seen = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    pulse_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n),
        .src_full(src_full), .src_div8(src_div8), .src_div32(src_div32), .src_sub(src_sub),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .port_val(port_val), .pulse_out(pulse_out), .pulse_out_n(pulse_out_n),
        .irq_underflow(irq_underflow), .irq_edge(irq_edge)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Monitor: counts interrupts and scores them against the queue.
    always @(negedge clk) begin
        if (irq_underflow) uf_seen++;
        if (irq_edge) edge_seen++;
        if (mon_on && (irq_underflow || irq_edge)) begin
            if (!irq_underflow) begin
                chk(1'b0, "R6 edge without wrap", 1, 0);
            end else if (sb_q.size() == 0) begin
                chk(1'b0, "R3 unexpected wrap", cyc, -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(cyc == e.cyc, "R3 R7 wrap cycle", cyc, e.cyc);
                chk(pulse_out == e.lvl, "R5 output level", pulse_out, e.lvl);
                chk(irq_edge == e.edg, "R6 edge irq", irq_edge, e.edg);
                chk(pulse_out_n == ~pulse_out, "R8 complement", pulse_out_n, !pulse_out);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = rd_data;
    endtask

    // Driver: program, start, and push the expected wraps.
    task automatic run_sched(input int n, input int m, input bit pol, input int k);
        int p;
        int c0;
        p = (n + 1) * (m + 1);
        wr(2'd0, 8'(n));
        wr(2'd1, 8'(m));
        wr(2'd2, {3'b000, 1'b1, 1'b1, pol, 2'b00});
        c0 = cyc;
        for (int i = 1; i <= k; i++) begin
            exp_t e;
            e.cyc = c0 + i * p;
            e.lvl = (!pol) ^ (i % 2 == 1);
            e.edg = (i % 2 == 0);
            sb_q.push_back(e);
        end
        mon_on = 1'b1;
        repeat (k * p + 1) @(negedge clk);
        wr(2'd2, {3'b000, 1'b1, 1'b0, pol, 2'b00});
        @(negedge clk);
        mon_on = 1'b0;
        chk(sb_q.size() == 0, "R3 all wraps seen", sb_q.size(), 0);
        sb_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, v2, u0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R8 port passthrough
        rd(2'd2, v); chk(v == 0, "R10 control reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R10 timer reset", v, 0);
        chk(pulse_out == 1'b1, "R10 output high", pulse_out, 1);
        chk(irq_underflow == 1'b0 && irq_edge == 1'b0, "R10 irqs low", irq_underflow, 0);
        chk(pulse_out_n == 1'b1, "R8 port value", pulse_out_n, 1);
        port_val = 1'b0; #1;
        chk(pulse_out_n == 1'b0, "R8 port value low", pulse_out_n, 0);

        // R9 write/read
        wr(2'd0, 8'd3); rd(2'd0, v); chk(v == 3, "R9 prescaler readback", v, 3);
        wr(2'd1, 8'd2); rd(2'd1, v); chk(v == 2, "R9 timer readback", v, 2);

        // R3 R5 R6 R7 scoreboard run, polarity 0
        src_full = 1'b1;
        run_sched(3, 2, 1'b0, 3);

        // R4 hold while stopped
        rd(2'd1, v);
        repeat (10) @(negedge clk);
        rd(2'd1, v2);
        chk(v == v2, "R4 timer holds", v2, v);
        chk(pulse_out == 1'b0, "R4 output holds", pulse_out, 0);

        // R11 forced level, no edge irq
        e0 = edge_seen;
        wr(2'd2, 8'b0000_0100);
        chk(pulse_out == 1'b0, "R11 pol1 level", pulse_out, 0);
        wr(2'd2, 8'b0000_0000);
        chk(pulse_out == 1'b1, "R11 pol0 level", pulse_out, 1);
        @(negedge clk);
        chk(edge_seen == e0, "R11 no edge irq", edge_seen, e0);

        // R6 polarity 1 run (forced low at start)
        run_sched(1, 1, 1'b1, 4);

        // R1 source select
        src_full = 1'b1; src_div8 = 1'b1; src_sub = 1'b1; src_div32 = 1'b0;
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd5);
        wr(2'd2, 8'b0000_1010);
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk(v == 5, "R1 unselected ignored", v, 5);
        src_div32 = 1'b1;
        @(negedge clk);
        src_div32 = 1'b0;
        rd(2'd1, v); chk(v == 4, "R1 div32 tick", v, 4);
        wr(2'd2, 8'b0000_1011);
        repeat (2) @(negedge clk);
        src_sub = 1'b0;
        rd(2'd1, v); chk(v == 2, "R1 sub tick", v, 2);
        wr(2'd2, 8'b0000_0011);
        src_div8 = 1'b0;

        // R12 write in the wrap cycle
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd3);
        u0 = uf_seen;
        wr(2'd2, 8'b0000_1000);
        repeat (3) @(negedge clk);
        reg_addr = 2'd1; wr_data = 8'd7; wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        v = rd_data;
        chk(v == 7, "R12 write wins", v, 7);
        chk(irq_underflow == 1'b0, "R12 wrap dropped", irq_underflow, 0);
        chk(pulse_out == 1'b1, "R12 no toggle", pulse_out, 1);
        @(negedge clk);
        chk(uf_seen == u0, "R12 no irq", uf_seen, u0);
        wr(2'd2, 8'b0000_0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule